// File: doc/BRIEF.md
# Privileged Register Access Router

This block decides where a software access to an interrupt-controller register goes. Each request carries the exception level it comes from. The block then applies an ordered chain of checks that belongs to that level. It uses the per-level system-register-interface enables, the level-2 enable and width flags, the level-3 width flag, a trap-all-group-0 control, a group-0 virtual routing bit and a level-3 routing bit. There are four possible results: the access is undefined, it traps to a named exception level, it reaches the virtual copy of the register, or it reaches the physical copy.

The decision is made combinationally when a request strobe arrives and is captured in a register stage. One cycle later the stage raises a one-cycle done pulse, and it holds the outcome, trap level and syndrome until the next request. While done is high, the stage steers a write strobe to the chosen copy, or returns that copy's read data. Faulting accesses never write, and they read as zero. The register contents live outside this block.

Top module: `sysreg_access_router`

## Requirements
- R1: A request from level 0 (`cur_el`=0) always gives outcome 2'b11 (undefined), whatever the other inputs are.
- R2: A level-1 request uses the first matching rule, in this order: `iface_en[0]`=0 traps to level 1. Level 2 active (`el2_on` and `el2_wide`) with `trap_grp0` traps to level 2. Level 2 active with `grp0_virt` gives outcome 2'b01 (virtual). `el3_wide` with `el3_route` traps to level 3. Anything else gives outcome 2'b00 (physical).
- R3: A level-2 request traps to level 2 when `iface_en[1]`=0. Otherwise it traps to level 3 when `el3_wide` and `el3_route` are both set. Otherwise it is physical. `trap_grp0` and `grp0_virt` have no effect at level 2.
- R4: A level-3 request traps to level 3 when `iface_en[2]`=0 and is physical otherwise. No routing bit has any effect at level 3.
- R5: The outcome code for a trap is 2'b10. On a trap, `trap_lvl` gives the target level (1, 2 or 3) and `syndrome` reads 6'h18. For every other outcome, both fields read zero.
- R6: The outcome fields update on the clock edge that samples `req_vld`=1. `done` is high for exactly the one cycle after that edge. The fields hold their values until the next request.
- R7: While `done` is high, a write with a physical outcome pulses `wr_phys` and a write with a virtual outcome pulses `wr_virt`. A read, a trap or an undefined access pulses neither, and both strobes are never high together.
- R8: While `done` is high for a read, `rd_data` equals `rd_phys` for a physical outcome and `rd_virt` for a virtual outcome. It is zero for a trap, for an undefined access, for a write, and whenever `done` is low.
- R9: After reset, `done`, `outcome`, `trap_lvl`, `syndrome`, both write strobes and `rd_data` are all zero.
- R10: Reads and writes with the same routing inputs give the same outcome, trap level and syndrome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Access request strobe |
| req_wr | input | 1 | 1 = write access, 0 = read access |
| cur_el | input | 2 | Exception level of the requester (0 to 3) |
| iface_en | input | 3 | System-register interface enable; bit i is for level i+1 |
| el2_on | input | 1 | Level 2 is enabled |
| el2_wide | input | 1 | Level 2 runs in 64-bit state |
| el3_wide | input | 1 | Level 3 is implemented and runs in 64-bit state |
| trap_grp0 | input | 1 | Trap all group-0 accesses from level 1 to level 2 |
| grp0_virt | input | 1 | Route level-1 group-0 accesses to the virtual copy |
| el3_route | input | 1 | Route accesses to level 3 |
| rd_phys | input | DW | Read data from the physical copy |
| rd_virt | input | DW | Read data from the virtual copy |
| done | output | 1 | One-cycle completion pulse |
| outcome | output | 2 | 00 physical, 01 virtual, 10 trap, 11 undefined |
| trap_lvl | output | 2 | Trap target level; zero unless the outcome is trap |
| syndrome | output | 6 | Syndrome class; 6'h18 on a trap, zero otherwise |
| wr_phys | output | 1 | Write strobe to the physical copy |
| wr_virt | output | 1 | Write strobe to the virtual copy |
| rd_data | output | DW | Read data returned to the requester |

## Verification
The bench targets the places where two level-1 rules are true at the same time:
- A disabled interface together with trap-all set must trap to level 1. A reversed chain would trap to level 2 instead.
- Trap-all together with virtual routing must trap rather than reach the virtual copy.
- Virtual routing with level 2 disabled, or not in 64-bit state, must fall through to the level-3 or physical rules. A design that ignored the width flag would wrongly hand out the virtual copy.

The bench also sets the level-1 controls during level-2 and level-3 accesses, where they must have no effect. It checks that a trap or undefined access leaves both write strobes low and reads zero, which catches a design that wrote on a fault or leaked the physical data.

// File: rtl/rtr_pkg.sv
package rtr_pkg;

  typedef enum logic [1:0] {
    OC_PHYS  = 2'b00,
    OC_VIRT  = 2'b01,
    OC_TRAP  = 2'b10,
    OC_UNDEF = 2'b11
  } outcome_e;

  localparam int LVL_W  = 2;
  localparam int NUM_LVL = 1 << LVL_W;
  localparam int EN_W   = NUM_LVL - 1;
  localparam int NCOPY  = 2;
  localparam int SEL_W  = $clog2(NCOPY);
  localparam int SYND_W = 6;
  localparam logic [SYND_W-1:0] SYND_CLASS = 6'h18;

  typedef struct packed {
    outcome_e         oc;
    logic [LVL_W-1:0] lvl;
  } verdict_t;

  function automatic verdict_t trap_to(input logic [LVL_W-1:0] tgt);
    verdict_t v;
    v.oc  = OC_TRAP;
    v.lvl = tgt;
    return v;
  endfunction

  // Ordered priority chain, evaluated per requesting level.
  function automatic verdict_t resolve(
    input logic [LVL_W-1:0] el,
    input logic [EN_W-1:0]  en,
    input logic             l2_on,
    input logic             l2_wide,
    input logic             l3_wide,
    input logic             tall0,
    input logic             virt0,
    input logic             route3
  );
    verdict_t v;
    logic l2_act;
    logic l3_take;
    l2_act  = l2_on & l2_wide;
    l3_take = l3_wide & route3;
    v.oc    = OC_PHYS;
    v.lvl   = '0;
    unique case (el)
      2'd0: v.oc = OC_UNDEF;
      2'd1: begin
        if (!en[0])                v = trap_to(2'd1);
        else if (l2_act && tall0)  v = trap_to(2'd2);
        else if (l2_act && virt0)  v.oc = OC_VIRT;
        else if (l3_take)          v = trap_to(2'd3);
      end
      2'd2: begin
        if (!en[1])                v = trap_to(2'd2);
        else if (l3_take)          v = trap_to(2'd3);
      end
      default: begin
        if (!en[2])                v = trap_to(2'd3);
      end
    endcase
    return v;
  endfunction

endpackage

// File: rtl/route_decide.sv
module route_decide
  import rtr_pkg::*;
(
  input  logic [LVL_W-1:0] cur_el,
  input  logic [EN_W-1:0]  iface_en,
  input  logic             el2_on,
  input  logic             el2_wide,
  input  logic             el3_wide,
  input  logic             trap_grp0,
  input  logic             grp0_virt,
  input  logic             el3_route,
  output verdict_t         verdict
);
  always_comb begin
    verdict = resolve(cur_el, iface_en, el2_on, el2_wide, el3_wide,
                      trap_grp0, grp0_virt, el3_route);
  end
endmodule

// File: rtl/route_stage.sv
module route_stage
  import rtr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic              req_wr,
  input  verdict_t          verdict_in,
  output logic              done_q,
  output logic              wr_q,
  output verdict_t          verdict_q,
  output logic [SYND_W-1:0] synd_q
);
  logic trap_in;
  assign trap_in = (verdict_in.oc == OC_TRAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q    <= 1'b0;
      wr_q      <= 1'b0;
      verdict_q <= '{oc: OC_PHYS, lvl: '0};
      synd_q    <= '0;
    end else begin
      done_q <= req_vld;
      if (req_vld) begin
        wr_q      <= req_wr;
        verdict_q <= verdict_in;
        synd_q    <= trap_in ? SYND_CLASS : '0;
      end
    end
  end
endmodule

// File: rtl/copy_select.sv
module copy_select
  import rtr_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          done_q,
  input  logic          wr_q,
  input  outcome_e      oc_q,
  input  logic [DW-1:0] rd_copy [NCOPY],
  output logic [NCOPY-1:0] wr_copy,
  output logic [DW-1:0] rd_data
);
  logic             hit;
  logic [SEL_W-1:0] sel_idx;

  // Physical and virtual codes differ only in bit 0; bit 1 flags a fault.
  assign hit     = done_q & ~oc_q[1];
  assign sel_idx = oc_q[SEL_W-1:0];

  for (genvar c = 0; c < NCOPY; c++) begin : g_wr
    assign wr_copy[c] = hit & wr_q & (sel_idx == SEL_W'(c));
  end

  always_comb begin
    rd_data = '0;
    if (hit && !wr_q) rd_data = rd_copy[sel_idx];
  end
endmodule

// File: rtl/sysreg_access_router.sv
module sysreg_access_router
  import rtr_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_vld,
  input  logic          req_wr,
  input  logic [1:0]    cur_el,
  input  logic [2:0]    iface_en,
  input  logic          el2_on,
  input  logic          el2_wide,
  input  logic          el3_wide,
  input  logic          trap_grp0,
  input  logic          grp0_virt,
  input  logic          el3_route,
  input  logic [DW-1:0] rd_phys,
  input  logic [DW-1:0] rd_virt,
  output logic          done,
  output logic [1:0]    outcome,
  output logic [1:0]    trap_lvl,
  output logic [5:0]    syndrome,
  output logic          wr_phys,
  output logic          wr_virt,
  output logic [DW-1:0] rd_data
);
  verdict_t         verdict_now;
  verdict_t         verdict_q;
  logic             done_q;
  logic             wr_q;
  logic [SYND_W-1:0] synd_q;
  logic [NCOPY-1:0] wr_copy;
  logic [DW-1:0]    rd_copy [NCOPY];

  route_decide u_decide (
    .cur_el    (cur_el),
    .iface_en  (iface_en),
    .el2_on    (el2_on),
    .el2_wide  (el2_wide),
    .el3_wide  (el3_wide),
    .trap_grp0 (trap_grp0),
    .grp0_virt (grp0_virt),
    .el3_route (el3_route),
    .verdict   (verdict_now)
  );

  route_stage u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_vld    (req_vld),
    .req_wr     (req_wr),
    .verdict_in (verdict_now),
    .done_q     (done_q),
    .wr_q       (wr_q),
    .verdict_q  (verdict_q),
    .synd_q     (synd_q)
  );

  assign rd_copy[0] = rd_phys;
  assign rd_copy[1] = rd_virt;

  copy_select #(.DW(DW)) u_sel (
    .done_q  (done_q),
    .wr_q    (wr_q),
    .oc_q    (verdict_q.oc),
    .rd_copy (rd_copy),
    .wr_copy (wr_copy),
    .rd_data (rd_data)
  );

  assign done     = done_q;
  assign outcome  = verdict_q.oc;
  assign trap_lvl = verdict_q.lvl;
  assign syndrome = synd_q;
  assign wr_phys  = wr_copy[0];
  assign wr_virt  = wr_copy[1];
endmodule

// File: rtl/rtr_checker.sv
module rtr_checker #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_vld,
  input logic [1:0]    cur_el,
  input logic [2:0]    iface_en,
  input logic          done,
  input logic [1:0]    outcome,
  input logic [1:0]    trap_lvl,
  input logic [5:0]    syndrome,
  input logic          wr_phys,
  input logic          wr_virt,
  input logic [DW-1:0] rd_data
);
  AST_EL0_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && cur_el == 2'd0) |=> (outcome == 2'b11)); // R1

  AST_EL3_NO_VIRT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && cur_el == 2'd3 && iface_en[2]) |=> (outcome == 2'b00)); // R4

  AST_TRAP_SYND: assert property (@(posedge clk) disable iff (!rst_n)
    (outcome == 2'b10) |-> (syndrome == 6'h18 && trap_lvl != 2'd0)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> done); // R6

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !done); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> $stable(outcome)); // R6

  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_phys, wr_virt})); // R7

  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    outcome[1] |-> (!wr_phys && !wr_virt)); // R7

  AST_FAULT_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (outcome[1] || !done) |-> (rd_data == '0)); // R8
endmodule

bind sysreg_access_router rtr_checker #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_vld  (req_vld),
  .cur_el   (cur_el),
  .iface_en (iface_en),
  .done     (done),
  .outcome  (outcome),
  .trap_lvl (trap_lvl),
  .syndrome (syndrome),
  .wr_phys  (wr_phys),
  .wr_virt  (wr_virt),
  .rd_data  (rd_data)
);

// File: tb/test_sysreg_access_router.sv
`timescale 1ns/1ps
module test_sysreg_access_router;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_vld = 1'b0;
  logic          req_wr = 1'b0;
  logic [1:0]    cur_el = '0;
  logic [2:0]    iface_en = '0;
  logic          el2_on = 1'b0, el2_wide = 1'b0, el3_wide = 1'b0;
  logic          trap_grp0 = 1'b0, grp0_virt = 1'b0, el3_route = 1'b0;
  logic [DW-1:0] rd_phys = '0, rd_virt = '0;
  logic          done, wr_phys, wr_virt;
  logic [1:0]    outcome, trap_lvl;
  logic [5:0]    syndrome;
  logic [DW-1:0] rd_data;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sysreg_access_router #(.DW(DW)) i_sysreg_access_router (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
    .cur_el(cur_el), .iface_en(iface_en), .el2_on(el2_on),
    .el2_wide(el2_wide), .el3_wide(el3_wide), .trap_grp0(trap_grp0),
    .grp0_virt(grp0_virt), .el3_route(el3_route), .rd_phys(rd_phys),
    .rd_virt(rd_virt), .done(done), .outcome(outcome),
    .trap_lvl(trap_lvl), .syndrome(syndrome), .wr_phys(wr_phys),
    .wr_virt(wr_virt), .rd_data(rd_data)
  );

  task automatic chk(input string rq, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // Expected {outcome, trap level}, written as a flat rule table walk.
  function automatic logic [3:0] model(input logic [1:0] el, input logic [2:0] en,
      input logic e2, input logic e2w, input logic e3w,
      input logic ta, input logic gv, input logic r3);
    bit hyp = e2 && e2w;
    bit mon = e3w && r3;
    if (el == 0) return 4'b11_00;
    if (el == 3) return en[2] ? 4'b00_00 : 4'b10_11;
    if (el == 2) begin
      if (!en[1]) return 4'b10_10;
      return mon ? 4'b10_11 : 4'b00_00;
    end
    if (!en[0])       return 4'b10_01;
    if (hyp && ta)    return 4'b10_10;
    if (hyp && gv)    return 4'b01_00;
    if (mon)          return 4'b10_11;
    return 4'b00_00;
  endfunction

  task automatic access(input logic [1:0] el, input logic [2:0] en,
      input logic e2, input logic e2w, input logic e3w,
      input logic ta, input logic gv, input logic r3, input logic wr,
      input string rq);
    logic [3:0] exp;
    logic [1:0] eoc;
    logic [DW-1:0] erd;
    @(negedge clk);
    cur_el = el; iface_en = en; el2_on = e2; el2_wide = e2w; el3_wide = e3w;
    trap_grp0 = ta; grp0_virt = gv; el3_route = r3; req_wr = wr;
    rd_phys = {$urandom, $urandom}; rd_virt = {$urandom, $urandom};
    req_vld = 1'b1;
    @(negedge clk);
    req_vld = 1'b0;
    exp = model(el, en, e2, e2w, e3w, ta, gv, r3);
    eoc = exp[3:2];
    erd = '0;
    if (!wr && eoc == 2'b00) erd = rd_phys;
    if (!wr && eoc == 2'b01) erd = rd_virt;
    chk({rq, " outcome"}, DW'(outcome), DW'(eoc));
    chk("R5 trap_lvl", DW'(trap_lvl), DW'(exp[1:0]));
    chk("R5 syndrome", DW'(syndrome), (eoc == 2'b10) ? DW'(6'h18) : '0);
    chk("R6 done high", DW'(done), 1);
    chk("R7 wr_phys", DW'(wr_phys), DW'(wr && eoc == 2'b00));
    chk("R7 wr_virt", DW'(wr_virt), DW'(wr && eoc == 2'b01));
    chk("R8 rd_data", rd_data, erd);
    @(negedge clk);
    chk("R6 done low", DW'(done), 0);
    chk("R6 outcome held", DW'(outcome), DW'(eoc));
    chk("R8 rd_data idle", rd_data, '0);
  endtask

  initial begin
    #(8 * 150000);
    n_errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    logic [3:0] ra, rb;
    void'($urandom(32'd11));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 done", DW'(done), 0);
    chk("R9 outcome", DW'(outcome), 0);
    chk("R9 trap_lvl", DW'(trap_lvl), 0);
    chk("R9 syndrome", DW'(syndrome), 0);
    chk("R9 strobes", DW'({wr_phys, wr_virt}), 0);
    chk("R9 rd_data", rd_data, '0);
    rst_n = 1'b1;

    access(2'd0, 3'b111, 1, 1, 1, 1, 1, 1, 1'b1, "R1 el0 all set");
    access(2'd0, 3'b000, 0, 0, 0, 0, 0, 0, 1'b0, "R1 el0 all clear");
    access(2'd1, 3'b110, 1, 1, 1, 1, 1, 1, 1'b1, "R2 en clear beats trap-all");
    access(2'd1, 3'b001, 1, 1, 1, 1, 1, 1, 1'b0, "R2 trap-all beats virt");
    access(2'd1, 3'b001, 1, 1, 1, 0, 1, 1, 1'b1, "R2 virt beats el3");
    access(2'd1, 3'b001, 1, 0, 1, 1, 1, 1, 1'b0, "R2 el2 narrow falls to el3");
    access(2'd1, 3'b001, 0, 1, 0, 1, 1, 1, 1'b0, "R2 el2 off, el3 narrow");
    access(2'd1, 3'b001, 1, 1, 0, 0, 1, 0, 1'b0, "R2 virtual read");
    access(2'd2, 3'b101, 1, 1, 1, 1, 1, 1, 1'b1, "R3 el2 en clear");
    access(2'd2, 3'b010, 1, 1, 0, 1, 1, 1, 1'b1, "R3 level1 bits ignored");
    access(2'd2, 3'b010, 0, 0, 1, 0, 0, 1, 1'b0, "R3 trap el3");
    access(2'd3, 3'b011, 1, 1, 1, 1, 1, 1, 1'b0, "R4 el3 en clear");
    access(2'd3, 3'b100, 1, 1, 1, 1, 1, 1, 1'b1, "R4 route bits ignored");

    // R10: identical routing for read and write
    for (int i = 0; i < 40; i++) begin
      logic [1:0] el = 2'($urandom);
      logic [2:0] en = 3'($urandom);
      logic [5:0] f = 6'($urandom);
      access(el, en, f[0], f[1], f[2], f[3], f[4], f[5], 1'b0, "R10 read");
      ra = {outcome, trap_lvl};
      access(el, en, f[0], f[1], f[2], f[3], f[4], f[5], 1'b1, "R10 write");
      rb = {outcome, trap_lvl};
      chk("R10 read/write match", DW'(rb), DW'(ra));
    end

    for (int i = 0; i < 400; i++) begin
      logic [1:0] el = 2'($urandom);
      logic [2:0] en = 3'($urandom) | (($urandom % 4 != 0) ? 3'b111 : 3'b000);
      logic [6:0] f = 7'($urandom);
      access(el, en, f[0], f[1], f[2], f[3], f[4], f[5], f[6],
             (el == 0) ? "R1 random" : (el == 1) ? "R2 random" :
             (el == 2) ? "R3 random" : "R4 random");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule